// File: doc/BRIEF.md
# VLAN Tag Frame Length Extender

This block sits beside a receive MAC and follows the byte stream of an incoming Ethernet frame. It takes the two bytes in the type/length position (bytes 13 and 14), compares them with two programmable tag protocol IDs and works out how long the frame may legally be. The first ID marks a single-tagged frame, which is allowed 4 extra bytes. The second ID marks an extended-tag frame, which is allowed 20 extra bytes.

While the frame arrives, the block counts the accepted bytes. It raises an oversize flag as soon as the count goes past the effective limit. The flag stays up until the next frame starts. The limit is presented as an output so that downstream logic can apply the same length budget. Parsing of the tag control fields that follow the ID is left to other logic.

Top module: `vlan_len_ext`

## Requirements
- R1: While reset is asserted and after it is released, tag_single, tag_ext and too_long are 0 and max_len equals the effective base length.
- R2: Bytes are counted from 1, starting at the byte that carries rx_sof. Byte 13 is the high-order byte and byte 14 the low-order byte of the 16-bit candidate ID. A matching value at any other position has no effect.
- R3: If the candidate equals a nonzero tpid_single (and R6 does not apply), tag_single is 1 from the cycle after byte 14 and max_len is the base plus 4.
- R4: If the candidate equals a nonzero tpid_ext, tag_ext is 1 from the cycle after byte 14 and max_len is the base plus 20.
- R5: An ID register holding zero never matches, even when the candidate is 0x0000.
- R6: If both registers match, tag_ext is 1 and tag_single stays 0.
- R7: When base_max_len is 0, the base length is 1518. Otherwise the base length is base_max_len.
- R8: too_long becomes 1 in the cycle after the byte whose count exceeds max_len, and it holds through the end of the frame until the next rx_sof byte.
- R9: An rx_sof byte clears tag_single, tag_ext, too_long and the byte count, and counts as byte 1.
- R10: The ID registers are sampled only at byte 14. Changing them later in the frame does not alter that frame's flags.
- R11: The oversize test at byte 14 already uses the extension decided by that same byte.
- R12: Cycles with rx_valid low change no output and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A byte is present on rx_data |
| rx_sof | input | 1 | Current byte is the first of a frame |
| rx_eof | input | 1 | Current byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| tpid_single | input | 16 | Tag ID that grants a 4-byte extension, 0 disables it |
| tpid_ext | input | 16 | Tag ID that grants a 20-byte extension, 0 disables it |
| base_max_len | input | 16 | Untagged length limit, 0 selects 1518 |
| tag_single | output | 1 | Frame carries the single-tag ID |
| tag_ext | output | 1 | Frame carries the extended-tag ID |
| max_len | output | 17 | Effective maximum frame length in bytes |
| too_long | output | 1 | Byte count has exceeded max_len in this frame |

## Verification
Two functions can decide in the same cycle: the tag decision at byte 14 and the oversize test. The bench provokes this by setting base_max_len to 13, so byte 14 alone would overflow an untagged frame. Sent with a matching ID, that byte must leave too_long low; sent with a foreign ID, it must raise too_long. The second coincidence is a start byte that arrives right after an oversize frame, or a one-byte frame whose start and end strobes coincide; in both cases the clear has to win.

// File: rtl/vlan_len_ext.sv
module vlan_len_ext #(
  parameter int LEN_W       = 16,
  parameter int DEF_MAX     = 1518,
  parameter int EXT_SINGLE  = 4,
  parameter int EXT_WIDE    = 20,
  parameter int HI_POS      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  input  logic [15:0]      tpid_single,
  input  logic [15:0]      tpid_ext,
  input  logic [LEN_W-1:0] base_max_len,
  output logic             tag_single,
  output logic             tag_ext,
  output logic [LEN_W:0]   max_len,
  output logic             too_long
);

  localparam logic [LEN_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] HI_CNT  = LEN_W'(HI_POS - 1);
  localparam logic [LEN_W-1:0] LO_CNT  = LEN_W'(HI_POS);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [7:0]       hi_q;
  logic             sgl_d, ext_d, tl_d;
  logic             at_hi, at_lo, hit_ext, hit_sgl;
  logic [15:0]      cand;
  logic [LEN_W:0]   base_eff, lim_d;

  assign base_eff = (base_max_len == '0) ? (LEN_W+1)'(DEF_MAX) : {1'b0, base_max_len};
  assign max_len  = base_eff + (tag_ext ? (LEN_W+1)'(EXT_WIDE) :
                                tag_single ? (LEN_W+1)'(EXT_SINGLE) : '0);

  assign at_hi   = rx_valid && !rx_sof && (cnt_q == HI_CNT);
  assign at_lo   = rx_valid && !rx_sof && (cnt_q == LO_CNT);
  assign cand    = {hi_q, rx_data};
  assign hit_ext = (tpid_ext != '0) && (cand == tpid_ext);
  assign hit_sgl = (tpid_single != '0) && (cand == tpid_single) && !hit_ext;

  always_comb begin
    cnt_d = cnt_q;
    sgl_d = tag_single;
    ext_d = tag_ext;
    if (rx_valid) begin
      if (rx_sof) begin
        cnt_d = LEN_W'(1);
        sgl_d = 1'b0;
        ext_d = 1'b0;
      end else begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (at_lo) begin
          sgl_d = hit_sgl;
          ext_d = hit_ext;
        end
      end
    end
    lim_d = base_eff + (ext_d ? (LEN_W+1)'(EXT_WIDE) :
                        sgl_d ? (LEN_W+1)'(EXT_SINGLE) : '0);
    tl_d  = too_long;
    if (rx_valid)
      tl_d = (rx_sof ? 1'b0 : too_long) | ({1'b0, cnt_d} > lim_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      hi_q       <= '0;
      tag_single <= 1'b0;
      tag_ext    <= 1'b0;
      too_long   <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      tag_single <= sgl_d;
      tag_ext    <= ext_d;
      too_long   <= tl_d;
      if (at_hi) hi_q <= rx_data;
    end
  end

  // R9
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof) |=> (!tag_single && !tag_ext && !too_long));

  // R8
  tl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (too_long && !(rx_valid && rx_sof)) |=> too_long);

  // R12
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(tag_single) && $stable(tag_ext) && $stable(too_long)));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && (rx_sof || at_lo)) |=> ($stable(tag_single) && $stable(tag_ext)));

  // R5
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_lo && tpid_single == '0 && tpid_ext == '0) |=> (!tag_single && !tag_ext));

  // R6
  one_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_single && tag_ext));

  wire unused_ok = rx_eof;

endmodule

// File: tb/tb_vlan_len_ext.sv
module tb_vlan_len_ext;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 0;
  logic [15:0] tpid_single = 16'h8100, tpid_ext = 16'h88A8, base_max_len = 0;
  logic tag_single, tag_ext, too_long;
  logic [16:0] max_len;

  int checks = 0, fails = 0;
  int m_cnt, m_lim; logic [7:0] m_hi; logic m_s, m_e, m_tl;

  vlan_len_ext dut (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .tpid_single(tpid_single), .tpid_ext(tpid_ext),
    .base_max_len(base_max_len), .tag_single(tag_single), .tag_ext(tag_ext),
    .max_len(max_len), .too_long(too_long));

  always #4 clk = ~clk;

  function automatic int base_of();
    return (base_max_len == 0) ? 1518 : int'(base_max_len);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hi = 0; m_s = 0; m_e = 0; m_tl = 0;
    end else if (rx_valid) begin
      if (rx_sof) begin
        m_cnt = 1; m_s = 0; m_e = 0; m_tl = 0;
      end else begin
        if (m_cnt < 65535) m_cnt++;
        if (m_cnt == 13) m_hi = rx_data;
        else if (m_cnt == 14) begin
          m_e = (tpid_ext != 0) && ({m_hi, rx_data} == tpid_ext);
          m_s = !m_e && (tpid_single != 0) && ({m_hi, rx_data} == tpid_single);
        end
      end
      m_lim = base_of() + (m_e ? 20 : m_s ? 4 : 0);
      if (m_cnt > m_lim) m_tl = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 tag_single", tag_single, m_s);
    chk("R4 tag_ext", tag_ext, m_e);
    chk("R7 max_len", max_len, base_of() + (m_e ? 20 : m_s ? 4 : 0));
    chk("R8 too_long", too_long, m_tl);
  end

  task automatic put(logic v, logic s, logic e, logic [7:0] d);
    @(posedge clk); #1;
    rx_valid = v; rx_sof = s; rx_eof = e; rx_data = d;
  endtask

  task automatic frame(int len, logic [15:0] id, int gap);
    for (int k = 1; k <= len; k++) begin
      logic [7:0] d;
      d = (k == 13) ? id[15:8] : (k == 14) ? id[7:0] : 8'(k * 7);
      if (k == 11) d = id[15:8];
      if (k == 12) d = id[7:0];
      put(1, k == 1, k == len, d);
      if (gap != 0 && k % gap == 0) put(0, 0, 0, 8'hEE);
    end
    put(0, 0, 0, 0);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tag_single in reset", tag_single, 0);
    chk("R1 too_long in reset", too_long, 0);
    chk("R1 max_len in reset", max_len, 1518);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R1 tag_ext after reset", tag_ext, 0);

    frame(1522, 16'h8100, 0);
    chk("R3 single tag", tag_single, 1);
    chk("R3 single max", max_len, 1522);
    chk("R3 1522 not long", too_long, 0);
    frame(1523, 16'h8100, 5);
    chk("R8 1523 single long", too_long, 1);
    put(0, 0, 0, 0); @(negedge clk);
    chk("R12 idle keeps too_long", too_long, 1);

    frame(1538, 16'h88A8, 0);
    chk("R4 ext tag", tag_ext, 1);
    chk("R4 ext max", max_len, 1538);
    chk("R4 1538 not long", too_long, 0);
    frame(1539, 16'h88A8, 0);
    chk("R8 1539 ext long", too_long, 1);

    frame(1519, 16'h0800, 3);
    chk("R2 untagged", tag_single | tag_ext, 0);
    chk("R8 1519 untagged long", too_long, 1);

    tpid_single = 16'h0000; tpid_ext = 16'h0000;
    frame(20, 16'h0000, 0);
    chk("R5 zero never matches", tag_single | tag_ext, 0);

    tpid_single = 16'h9100; tpid_ext = 16'h9100;
    frame(20, 16'h9100, 0);
    chk("R6 ext wins", tag_ext, 1);
    chk("R6 single low", tag_single, 0);

    tpid_single = 16'h8100; tpid_ext = 16'h88A8;
    base_max_len = 16'd64;
    frame(68, 16'h8100, 0);
    chk("R7 base input", max_len, 68);
    chk("R7 68 ok", too_long, 0);
    frame(13, 16'h8100, 0);
    chk("R2 short frame no tag", tag_single, 0);

    base_max_len = 16'd13;
    frame(14, 16'h8100, 0);
    chk("R11 same-cycle tag saves", too_long, 0);
    frame(14, 16'h1234, 0);
    chk("R11 untagged 14 long", too_long, 1);
    frame(1, 16'h1234, 0);
    chk("R9 sof clears too_long", too_long, 0);

    base_max_len = 16'd100;
    fork
      frame(30, 16'h88A8, 2);
      begin repeat (40) @(posedge clk); #2 tpid_ext = 16'h0000; end
    join
    chk("R10 late register change", tag_ext, 1);
    frame(2, 16'h88A8, 0);
    chk("R9 sof clears tag", tag_ext, 0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule